// File: doc/BRIEF.md
# Co-issue Split Vector ALU

This block is a four-lane signed fixed-point arithmetic unit. Each lane holds a Q8.8 value: 16 bits, two's complement, 8 fraction bits, so 1.0 is 0x0100. In one clock it runs either a single operation that spans all four lanes, or two independent operations that each own a disjoint group of lanes. The allowed splits are three lanes plus one lane, or two lanes plus two lanes.

Each issue slot carries the following:
- an opcode;
- a swizzle for each of its three sources;
- a lane group;
- a destination write mask;
- an output modifier, applied after the arithmetic.

The two slots take their operands from separate register-read buses sampled in the same cycle. Neither slot can see the other slot's result in that cycle. The merged result leaves through a registered write port one clock after issue, with a valid bit for each slot and a flag for an illegal issue.

Lane 0 (x) is bits [15:0] of every 64-bit vector, lane 1 (y) is [31:16], lane 2 (z) is [47:32] and lane 3 (w) is [63:48].

Top module: `coissue_valu`

## Requirements
- R1: With only slot 0 valid and `s0_lanes` = 4'b1111, the result of the operation appears on `out_data`/`out_wmask` at the first rising edge after issue, with `out_v0`=1, `out_v1`=0 and `out_illegal`=0.
- R2: With both slots valid, a legal issue has lane groups that are disjoint, cover all four lanes and are both non-empty (3+1 or 2+2). Each lane then carries the result of the slot that owns it, both valid bits are 1, and each slot computes only from its own source buses.
- R3: An issue is illegal in any of these cases: the groups overlap; the groups leave a lane uncovered; one group is empty while both slots are valid; slot 1 is valid alone; slot 0 is valid alone without all four lanes. An illegal issue gives `out_illegal`=1 one cycle later, with `out_wmask`=0, `out_data`=0 and both valid bits 0.
- R4: Bit i of `out_wmask` equals the write-mask bit i of the slot that owns lane i. Any lane that is not written reads 0 on `out_data`.
- R5: The opcode encodings are MOV=0 (a), ADD=1 (a+b), MUL=2 (a*b shifted right arithmetically by 8, i.e. floor) and MAD=3 (floor(a*b/256)+c).
- R6: DP3=4 sums the products of components 0, 1 and 2 of the swizzled a and b, shifts the sum right arithmetically by 8, and writes that one value to every lane of the slot's group.
- R7: Each swizzle has two bits per destination lane. Lane i reads bits [2i+1:2i], and their value picks the source component 0..3. 8'hE4 is the identity and 8'h00 replicates x to all lanes.
- R8: The modifier encodings are 0 = none, 1 = doubling (r*2) and 2 = bias-and-scale (2r-1.0). Encoding 3 acts as none. The modifier acts on the unclamped result.
- R9: Final lane results saturate to the range [-32768, 32767] raw (0x8000..0x7FFF) instead of wrapping.
- R10: While `rst_n` is low at a rising edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_valid | input | 1 | Slot 0 issues this cycle |
| s0_op | input | 3 | Slot 0 opcode |
| s0_mod | input | 2 | Slot 0 output modifier |
| s0_lanes | input | 4 | Slot 0 lane group |
| s0_wmask | input | 4 | Slot 0 destination write mask |
| s0_swz_a | input | 8 | Slot 0 swizzle of source a |
| s0_swz_b | input | 8 | Slot 0 swizzle of source b |
| s0_swz_c | input | 8 | Slot 0 swizzle of source c |
| s0_src_a | input | 64 | Slot 0 source a vector |
| s0_src_b | input | 64 | Slot 0 source b vector |
| s0_src_c | input | 64 | Slot 0 source c vector |
| s1_valid | input | 1 | Slot 1 issues this cycle |
| s1_op | input | 3 | Slot 1 opcode |
| s1_mod | input | 2 | Slot 1 output modifier |
| s1_lanes | input | 4 | Slot 1 lane group |
| s1_wmask | input | 4 | Slot 1 destination write mask |
| s1_swz_a | input | 8 | Slot 1 swizzle of source a |
| s1_swz_b | input | 8 | Slot 1 swizzle of source b |
| s1_swz_c | input | 8 | Slot 1 swizzle of source c |
| s1_src_a | input | 64 | Slot 1 source a vector |
| s1_src_b | input | 64 | Slot 1 source b vector |
| s1_src_c | input | 64 | Slot 1 source c vector |
| out_data | output | 64 | Registered merged lane results |
| out_wmask | output | 4 | Registered lane write enables |
| out_v0 | output | 1 | Slot 0 result valid |
| out_v1 | output | 1 | Slot 1 result valid |
| out_illegal | output | 1 | Previous issue was illegal |

## Verification
The full-width path is driven with each opcode on vectors that mix signs. Negative products show whether the shift floors, and large operands show whether results clamp or wrap. Co-issue is tried with a 3+1 split and with both a contiguous and an interleaved 2+2 split, each slot fed different operands and a different opcode. A lane routed to the wrong slot, or one slot reading the other's data, therefore gives a visibly wrong value. Every form of illegal lane pattern is issued once, and partial write masks and a broadcast swizzle separate masking and component selection from the arithmetic itself.

// File: rtl/covalu_pkg.sv
// Package: shared constants and encodings of the co-issue vector ALU.
// Assumes four lanes; the split legality rules are written for that count.
package covalu_pkg;
    localparam int LANES = 4;
    localparam int SELW  = 2;

    typedef enum logic [2:0] {
        OP_MOV = 3'd0,
        OP_ADD = 3'd1,
        OP_MUL = 3'd2,
        OP_MAD = 3'd3,
        OP_DP3 = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        MOD_NONE = 2'd0,
        MOD_X2   = 2'd1,
        MOD_BX2  = 2'd2
    } out_mod_e;
endpackage

// File: rtl/covalu_swizzle.sv
// Module: per-lane source component selector.
// Assumes sel holds SELW bits per destination lane, lane 0 in the low bits.
module covalu_swizzle
    import covalu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [LANES*DW-1:0]   src,
    input  logic [LANES*SELW-1:0] sel,
    output logic [LANES*DW-1:0]   dst
);
    // One selector for each destination lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dst[i*DW +: DW] = src[sel[i*SELW +: SELW]*DW +: DW];
    end
endmodule

// File: rtl/covalu_post.sv
// Module: output modifier (x2, 2r-1) followed by saturation to DW bits.
// Assumes raw is a wide signed value with FRAC fraction bits.
module covalu_post
    import covalu_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int WW   = 2*DW + 4
) (
    input  logic signed [WW-1:0] raw,
    input  logic [1:0]           mode,
    output logic [DW-1:0]        res
);
    localparam logic signed [WW-1:0] ONE  = WW'(1 << FRAC);
    localparam logic signed [WW-1:0] MAXV = WW'((1 << (DW-1)) - 1);
    localparam logic signed [WW-1:0] MINV = -MAXV - WW'(1);

    logic signed [WW-1:0] scaled;

    // Apply the modifier on the unclamped value, then clamp.
    always_comb begin
        case (mode)
            MOD_X2:  scaled = raw <<< 1;
            MOD_BX2: scaled = (raw <<< 1) - ONE;
            default: scaled = raw;
        endcase
        if (scaled > MAXV)      res = MAXV[DW-1:0];
        else if (scaled < MINV) res = MINV[DW-1:0];
        else                    res = scaled[DW-1:0];
    end

    // Overflow must pin to the top of the range, never wrap (R9).
    always_comb begin
        if (scaled > MAXV)
            assert_sat_high_R9: assert (res == {1'b0, {(DW-1){1'b1}}});
        if (scaled < MINV)
            assert_sat_low_R9: assert (res == {1'b1, {(DW-1){1'b0}}});
    end
endmodule

// File: rtl/covalu_slot.sv
// Module: one issue slot's datapath across all four lanes:
// swizzle, MOV/ADD/MUL/MAD/DP3, then modifier and saturation.
// Assumes the caller masks lanes outside the slot's group.
module covalu_slot
    import covalu_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic [2:0]            op,
    input  logic [1:0]            mode,
    input  logic [LANES*SELW-1:0] swz_a,
    input  logic [LANES*SELW-1:0] swz_b,
    input  logic [LANES*SELW-1:0] swz_c,
    input  logic [LANES*DW-1:0]   src_a,
    input  logic [LANES*DW-1:0]   src_b,
    input  logic [LANES*DW-1:0]   src_c,
    output logic [LANES*DW-1:0]   res
);
    localparam int WW = 2*DW + 4;

    logic [LANES*DW-1:0]  sw_a, sw_b, sw_c;
    logic signed [DW-1:0] av [LANES];
    logic signed [DW-1:0] bv [LANES];
    logic signed [DW-1:0] cv [LANES];
    logic signed [WW-1:0] prod [LANES];
    logic signed [WW-1:0] raw  [LANES];
    logic signed [WW-1:0] dot;

    covalu_swizzle #(.DW(DW)) i_swz_a (.src(src_a), .sel(swz_a), .dst(sw_a));
    covalu_swizzle #(.DW(DW)) i_swz_b (.src(src_b), .sel(swz_b), .dst(sw_b));
    covalu_swizzle #(.DW(DW)) i_swz_c (.src(src_c), .sel(swz_c), .dst(sw_c));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign av[i] = sw_a[i*DW +: DW];
        assign bv[i] = sw_b[i*DW +: DW];
        assign cv[i] = sw_c[i*DW +: DW];
        // Full-precision lane product.
        assign prod[i] = WW'(av[i]) * WW'(bv[i]);

        // Select the lane's raw result by opcode.
        always_comb begin
            case (op)
                OP_ADD:  raw[i] = WW'(av[i]) + WW'(bv[i]);
                OP_MUL:  raw[i] = prod[i] >>> FRAC;
                OP_MAD:  raw[i] = (prod[i] >>> FRAC) + WW'(cv[i]);
                OP_DP3:  raw[i] = dot;
                default: raw[i] = WW'(av[i]);
            endcase
        end

        covalu_post #(.DW(DW), .FRAC(FRAC), .WW(WW)) i_post (
            .raw  (raw[i]),
            .mode (mode),
            .res  (res[i*DW +: DW])
        );
    end

    // Three-component dot product, shared by every lane of the group.
    assign dot = (prod[0] + prod[1] + prod[2]) >>> FRAC;
endmodule

// File: rtl/covalu_issue_check.sv
// Module: decides whether a pair of issue slots forms a legal split.
// Assumes four lanes: one full op, or 3+1 / 2+2 disjoint covering groups.
module covalu_issue_check
    import covalu_pkg::*;
(
    input  logic             v0,
    input  logic             v1,
    input  logic [LANES-1:0] lanes0,
    input  logic [LANES-1:0] lanes1,
    output logic             ok
);
    localparam logic [LANES-1:0] ALL = '1;

    // Classify the issue pattern.
    always_comb begin
        if (v0 && !v1)
            ok = (lanes0 == ALL);
        else if (v0 && v1)
            ok = ((lanes0 & lanes1) == '0) && ((lanes0 | lanes1) == ALL)
                 && (lanes0 != '0) && (lanes1 != '0);
        else
            ok = 1'b0;
    end

    // A legal pair uses 1..3 lanes each, four in total (R2).
    always_comb begin
        if (ok && v1)
            assert_split_sizes_R2: assert (($countones(lanes0) + $countones(lanes1) == 4)
                && $countones(lanes0) >= 1 && $countones(lanes0) <= 3);
    end
endmodule

// File: rtl/coissue_valu.sv
// Module: top of the co-issue split vector ALU. Two slots share four
// Q8.8 lanes; results merge per lane owner and register once.
// Assumes operands are already read for both slots in the issue cycle.
module coissue_valu
    import covalu_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s0_valid,
    input  logic [2:0]           s0_op,
    input  logic [1:0]           s0_mod,
    input  logic [3:0]           s0_lanes,
    input  logic [3:0]           s0_wmask,
    input  logic [7:0]           s0_swz_a,
    input  logic [7:0]           s0_swz_b,
    input  logic [7:0]           s0_swz_c,
    input  logic [4*DW-1:0]      s0_src_a,
    input  logic [4*DW-1:0]      s0_src_b,
    input  logic [4*DW-1:0]      s0_src_c,
    input  logic                 s1_valid,
    input  logic [2:0]           s1_op,
    input  logic [1:0]           s1_mod,
    input  logic [3:0]           s1_lanes,
    input  logic [3:0]           s1_wmask,
    input  logic [7:0]           s1_swz_a,
    input  logic [7:0]           s1_swz_b,
    input  logic [7:0]           s1_swz_c,
    input  logic [4*DW-1:0]      s1_src_a,
    input  logic [4*DW-1:0]      s1_src_b,
    input  logic [4*DW-1:0]      s1_src_c,
    output logic [4*DW-1:0]      out_data,
    output logic [3:0]           out_wmask,
    output logic                 out_v0,
    output logic                 out_v1,
    output logic                 out_illegal
);
    localparam int VW = LANES*DW;

    logic [VW-1:0]    res0, res1, nxt_data;
    logic [LANES-1:0] nxt_we;
    logic             issue_ok;

    covalu_slot #(.DW(DW), .FRAC(FRAC)) i_slot0 (
        .op(s0_op), .mode(s0_mod),
        .swz_a(s0_swz_a), .swz_b(s0_swz_b), .swz_c(s0_swz_c),
        .src_a(s0_src_a), .src_b(s0_src_b), .src_c(s0_src_c),
        .res(res0)
    );

    covalu_slot #(.DW(DW), .FRAC(FRAC)) i_slot1 (
        .op(s1_op), .mode(s1_mod),
        .swz_a(s1_swz_a), .swz_b(s1_swz_b), .swz_c(s1_swz_c),
        .src_a(s1_src_a), .src_b(s1_src_b), .src_c(s1_src_c),
        .res(res1)
    );

    covalu_issue_check i_check (
        .v0(s0_valid), .v1(s1_valid),
        .lanes0(s0_lanes), .lanes1(s1_lanes),
        .ok(issue_ok)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_merge
        // Pick the owning slot of lane i and gate by its write mask.
        always_comb begin
            if (s1_valid && s1_lanes[i])
                nxt_we[i] = issue_ok && s1_wmask[i];
            else
                nxt_we[i] = issue_ok && s0_lanes[i] && s0_wmask[i];
            if (!nxt_we[i])
                nxt_data[i*DW +: DW] = '0;
            else if (s1_valid && s1_lanes[i])
                nxt_data[i*DW +: DW] = res1[i*DW +: DW];
            else
                nxt_data[i*DW +: DW] = res0[i*DW +: DW];
        end

        // An unwritten lane must read zero (R4).
        assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !out_wmask[i] |-> (out_data[i*DW +: DW] == '0));
    end

    // Output register of the merged write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_wmask   <= '0;
            out_v0      <= 1'b0;
            out_v1      <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_data    <= nxt_data;
            out_wmask   <= nxt_we;
            out_v0      <= s0_valid && issue_ok;
            out_v1      <= s1_valid && issue_ok;
            out_illegal <= (s0_valid || s1_valid) && !issue_ok;
        end
    end

    // A full-width single issue produces a slot-0 result next cycle (R1).
    assert_full_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && !s1_valid && s0_lanes == 4'hF) |=> (out_v0 && !out_v1 && !out_illegal));

    // A legal co-issue marks both slots valid next cycle (R2).
    assert_pair_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && (s0_lanes & s1_lanes) == 4'h0 && (s0_lanes | s1_lanes) == 4'hF
         && s0_lanes != 4'h0 && s1_lanes != 4'h0) |=> (out_v0 && out_v1));

    // An illegal issue writes nothing (R3).
    assert_illegal_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_wmask == 4'h0 && !out_v0 && !out_v1));

    // Lanes outside both owners' write masks stay unwritten (R4).
    assert_mask_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid || s1_valid) |=>
        ((out_wmask & ~$past((s0_lanes & s0_wmask) | (s1_valid ? (s1_lanes & s1_wmask) : 4'h0))) == 4'h0));
endmodule

// File: tb/test_coissue_valu.sv
// Directed bench for coissue_valu: one task per scenario, each checking itself.
module test_coissue_valu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s0_valid = 0, s1_valid = 0;
    logic [2:0]  s0_op = 0, s1_op = 0;
    logic [1:0]  s0_mod = 0, s1_mod = 0;
    logic [3:0]  s0_lanes = 0, s1_lanes = 0, s0_wmask = 0, s1_wmask = 0;
    logic [7:0]  s0_swz_a = 8'hE4, s0_swz_b = 8'hE4, s0_swz_c = 8'hE4;
    logic [7:0]  s1_swz_a = 8'hE4, s1_swz_b = 8'hE4, s1_swz_c = 8'hE4;
    logic [63:0] s0_src_a = 0, s0_src_b = 0, s0_src_c = 0;
    logic [63:0] s1_src_a = 0, s1_src_b = 0, s1_src_c = 0;
    logic [63:0] out_data;
    logic [3:0]  out_wmask;
    logic        out_v0, out_v1, out_illegal;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    coissue_valu i_coissue_valu (.*);

    function automatic logic [63:0] vec(logic [15:0] x, logic [15:0] y, logic [15:0] z, logic [15:0] w);
        return {w, z, y, x};
    endfunction

    // Expected lanes of one slot, from the requirement text.
    function automatic logic [63:0] model(logic [2:0] op, logic [1:0] md,
        logic [7:0] sa, logic [7:0] sb, logic [7:0] sc,
        logic [63:0] a, logic [63:0] b, logic [63:0] c);
        longint av[4], bv[4], cv[4], r, dsum;
        logic [63:0] o;
        for (int i = 0; i < 4; i++) begin
            av[i] = longint'($signed(a[16*sa[2*i +: 2] +: 16]));
            bv[i] = longint'($signed(b[16*sb[2*i +: 2] +: 16]));
            cv[i] = longint'($signed(c[16*sc[2*i +: 2] +: 16]));
        end
        dsum = (av[0]*bv[0] + av[1]*bv[1] + av[2]*bv[2]) >>> 8;
        for (int i = 0; i < 4; i++) begin
            case (op)
                3'd1: r = av[i] + bv[i];
                3'd2: r = (av[i]*bv[i]) >>> 8;
                3'd3: r = ((av[i]*bv[i]) >>> 8) + cv[i];
                3'd4: r = dsum;
                default: r = av[i];
            endcase
            if (md == 2'd1) r = 2*r;
            else if (md == 2'd2) r = 2*r - 256;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            o[16*i +: 16] = r[15:0];
        end
        return o;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue the programmed slots for one cycle and check the registered write.
    task automatic go(string tag, bit exp_ok);
        logic [63:0] r0, r1, ed;
        logic [3:0]  ew;
        r0 = model(s0_op, s0_mod, s0_swz_a, s0_swz_b, s0_swz_c, s0_src_a, s0_src_b, s0_src_c);
        r1 = model(s1_op, s1_mod, s1_swz_a, s1_swz_b, s1_swz_c, s1_src_a, s1_src_b, s1_src_c);
        ed = '0; ew = '0;
        if (exp_ok)
            for (int i = 0; i < 4; i++) begin
                if (s1_valid && s1_lanes[i]) begin
                    ew[i] = s1_wmask[i]; if (ew[i]) ed[16*i +: 16] = r1[16*i +: 16];
                end else if (s0_lanes[i]) begin
                    ew[i] = s0_wmask[i]; if (ew[i]) ed[16*i +: 16] = r0[16*i +: 16];
                end
            end
        @(negedge clk);
        chk({tag, " data"}, out_data, ed);
        chk({tag, " wmask"}, {60'd0, out_wmask}, {60'd0, ew});
        chk({tag, " flags"}, {61'd0, out_v0, out_v1, out_illegal},
            {61'd0, exp_ok && s0_valid, exp_ok && s1_valid, !exp_ok});
        s0_valid = 0; s1_valid = 0;
    endtask

    task automatic slot0(logic [2:0] op, logic [1:0] md, logic [3:0] ln, logic [3:0] wm);
        s0_valid = 1; s0_op = op; s0_mod = md; s0_lanes = ln; s0_wmask = wm;
        s0_swz_a = 8'hE4; s0_swz_b = 8'hE4; s0_swz_c = 8'hE4;
    endtask

    task automatic slot1(logic [2:0] op, logic [1:0] md, logic [3:0] ln, logic [3:0] wm);
        s1_valid = 1; s1_op = op; s1_mod = md; s1_lanes = ln; s1_wmask = wm;
        s1_swz_a = 8'hE4; s1_swz_b = 8'hE4; s1_swz_c = 8'hE4;
    endtask

    task automatic t_reset();   // R10
        @(negedge clk);
        chk("R10 reset outputs", {out_data[59:0], out_wmask}, 64'd0);
        chk("R10 reset flags", {61'd0, out_v0, out_v1, out_illegal}, 64'd0);
    endtask

    task automatic t_full_ops();   // R1, R5
        @(negedge clk);
        s0_src_a = vec(16'h0180, 16'hFE80, 16'h0040, 16'h0300);
        s0_src_b = vec(16'h0200, 16'h0100, 16'hFF00, 16'hFFFF);
        s0_src_c = vec(16'h0010, 16'h0020, 16'h0030, 16'h0040);
        slot0(3'd3, 2'd0, 4'hF, 4'hF); go("R1 R5 full MAD", 1);
        slot0(3'd1, 2'd0, 4'hF, 4'hF); go("R5 ADD", 1);
        slot0(3'd2, 2'd0, 4'hF, 4'hF); go("R5 MUL floor", 1);
        slot0(3'd0, 2'd0, 4'hF, 4'hF); go("R5 MOV", 1);
    endtask

    task automatic t_dp3();   // R6
        s0_src_a = vec(16'h0100, 16'h0200, 16'hFF80, 16'h7000);
        s0_src_b = vec(16'h0300, 16'h0080, 16'h0200, 16'h7000);
        slot0(3'd4, 2'd0, 4'hF, 4'hF); go("R6 DP3 broadcast", 1);
    endtask

    task automatic t_coissue();   // R2
        s0_src_a = vec(16'h0100, 16'h0200, 16'h0300, 16'h0400);
        s0_src_b = vec(16'h0080, 16'h0080, 16'h0080, 16'h0080);
        s1_src_a = vec(16'h1000, 16'h2000, 16'h3000, 16'h4000);
        s1_src_b = vec(16'h0001, 16'h0002, 16'h0003, 16'h0004);
        slot0(3'd4, 2'd0, 4'b0111, 4'b0111); slot1(3'd1, 2'd0, 4'b1000, 4'b1000);
        go("R2 split 3+1 DP3+ADD", 1);
        slot0(3'd2, 2'd0, 4'b0011, 4'b0011); slot1(3'd0, 2'd0, 4'b1100, 4'b1100);
        go("R2 split 2+2 low/high", 1);
        slot0(3'd1, 2'd0, 4'b0101, 4'b0101); slot1(3'd2, 2'd0, 4'b1010, 4'b1010);
        go("R2 split 2+2 interleaved", 1);
    endtask

    task automatic t_wmask();   // R4
        slot0(3'd1, 2'd0, 4'b0111, 4'b0101); slot1(3'd0, 2'd0, 4'b1000, 4'b0000);
        go("R4 partial write masks", 1);
        slot0(3'd0, 2'd0, 4'hF, 4'b1000); go("R4 alpha only", 1);
    endtask

    task automatic t_swizzle();   // R7
        s0_src_a = vec(16'h0100, 16'h0200, 16'hFF00, 16'h0080);
        s0_src_b = vec(16'h0180, 16'h0000, 16'h0000, 16'h0000);
        slot0(3'd2, 2'd0, 4'hF, 4'hF); s0_swz_b = 8'h00; go("R7 broadcast x of b", 1);
        slot0(3'd0, 2'd0, 4'hF, 4'hF); s0_swz_a = 8'h1B; go("R7 reversed a", 1);
    endtask

    task automatic t_modifier();   // R8
        s0_src_a = vec(16'h0080, 16'h0000, 16'hFF00, 16'h00C0);
        slot0(3'd0, 2'd1, 4'hF, 4'hF); go("R8 x2", 1);
        slot0(3'd0, 2'd2, 4'hF, 4'hF); go("R8 bias-scale", 1);
        slot0(3'd0, 2'd3, 4'hF, 4'hF); go("R8 code 3 none", 1);
    endtask

    task automatic t_saturate();   // R9
        s0_src_a = vec(16'h7000, 16'h8800, 16'h4000, 16'hC000);
        s0_src_b = vec(16'h2000, 16'hA000, 16'h0200, 16'h0300);
        slot0(3'd1, 2'd0, 4'hF, 4'hF); go("R9 ADD clamps", 1);
        slot0(3'd2, 2'd0, 4'hF, 4'hF); go("R9 MUL clamps", 1);
        s0_src_a = vec(16'h5000, 16'hB000, 16'h0100, 16'h0000);
        slot0(3'd0, 2'd1, 4'hF, 4'hF); go("R9 x2 clamps", 1);
    endtask

    task automatic t_illegal();   // R3
        slot0(3'd1, 2'd0, 4'b0111, 4'hF); slot1(3'd1, 2'd0, 4'b1100, 4'hF); go("R3 overlap", 0);
        slot0(3'd1, 2'd0, 4'b0011, 4'hF); slot1(3'd1, 2'd0, 4'b0100, 4'hF); go("R3 gap", 0);
        slot0(3'd1, 2'd0, 4'hF, 4'hF); slot1(3'd1, 2'd0, 4'h0, 4'hF); go("R3 4+0", 0);
        slot1(3'd1, 2'd0, 4'hF, 4'hF); go("R3 slot1 alone", 0);
        slot0(3'd1, 2'd0, 4'b0111, 4'hF); go("R3 slot0 partial alone", 0);
        slot0(3'd0, 2'd0, 4'hF, 4'hF); go("R3 legal after illegal", 1);
    endtask

    task automatic t_reset_mid();   // R10
        slot0(3'd0, 2'd0, 4'hF, 4'hF); s0_src_a = 64'h1234_5678_9ABC_DEF0;
        go("R10 before reset", 1);
        rst_n = 0;
        @(negedge clk);
        chk("R10 cleared by reset", {out_data[59:0], out_wmask}, 64'd0);
        rst_n = 1;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        t_full_ops();
        t_dp3();
        t_coissue();
        t_wmask();
        t_swizzle();
        t_modifier();
        t_saturate();
        t_illegal();
        t_reset_mid();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule